// File: doc/BRIEF.md
# Role Authentication Session Controller

This block admits one operator at a time under one of two roles, officer or user. It decides which service requests that operator may use. A login request carries a role and a 256-bit credential. The block holds the credential on a request/acknowledge port that leads to an external SHA-256 engine. When the engine answers, the block compares the returned digest with the stored digest for the claimed role. The stored digests are presented on input ports by a nonvolatile store outside the block. Only digests are kept there, never the credential itself.

Each attempt reports its outcome after a fixed number of cycles. A pass, a fail and a refusal all take the same time, and the outcome is a single bit. This limits how fast credentials can be guessed and hides the reason for a failure. While either role still carries its factory-set credential, the block grants only the credential-management service.

The active session can change the credentials: the block hashes the new credential and sends a one-cycle write to the store. The session can also wipe a stored digest. A session ends on logout, on the start of a sampling self-test, and on reset.

Top module: `role_auth_ctrl`

## Requirements
- R1: The role on `login_role` and `active_role` is encoded 1 for officer and 0 for user. `session_valid` is high exactly while a session exists. `active_role` reads 0 when no session exists.
- R2: A login with no session active compares `hash_digest` with `stored_dig_off` (officer) or `stored_dig_usr` (user). On a match, `auth_pass` is 1 and the session opens with the requested role. On a mismatch, `auth_pass` is 0 and no session opens.
- R3: A login request made while a session is active is refused with `auth_pass` 0. The open session and its role stay unchanged. A session keeps its role until it ends, so a different role needs a logout and a new login.
- R4: `auth_done` is a one-cycle pulse. It rises exactly ATTEMPT_CYCLES clock edges after the edge that accepts the login request. This holds for a pass, a fail and a refusal alike, provided the hash engine answers within ATTEMPT_CYCLES-2 cycles.
- R5: While `hash_req` is high, `hash_data` carries the credential being hashed and stays stable until the cycle in which `hash_ack` is high. The digest is taken in that cycle.
- R6: `svc_grant` equals `svc_req` ANDed with the mask of the active role. The officer mask defaults to 8'b1100_0011 and the user mask to 8'b0011_1101. With no session, `svc_grant` is 0.
- R7: While any bit of `factory_state` is set (bit 1 for officer, bit 0 for user), only service bit MGMT_IDX (default 0) can be granted.
- R8: A credential update is accepted only when the session holds the management service and either the session role is officer or the target is the session's own role. An accepted update hashes `upd_cred` and then pulses `nv_we` for one cycle, starting the cycle after the acknowledge. With that pulse, `nv_sel` is the target role, `nv_data` is the digest and `nv_clr_factory` is 1. A refused update raises neither `hash_req` nor `nv_we`.
- R9: A wipe request is accepted under the same rule as R8. An accepted wipe pulses `nv_we` in the cycle after the request, with `nv_data` all ones and `nv_clr_factory` 0. A refused wipe writes nothing.
- R10: A logout ends the session at the next edge. `selftest_start` ends the session and abandons any pending attempt, so no `auth_done` follows it.
- R11: During reset, `session_valid`, `active_role`, `auth_done`, `hash_req`, `nv_we` and `svc_grant` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| login_req | input | 1 | Login attempt strobe |
| login_role | input | 1 | Claimed role (1 officer, 0 user) |
| login_cred | input | 256 | Supplied credential |
| logout_req | input | 1 | End the current session |
| selftest_start | input | 1 | Sampling self-test begins; clears session |
| upd_req | input | 1 | Replace a credential |
| upd_role | input | 1 | Role whose credential is replaced |
| upd_cred | input | 256 | New credential |
| zero_req | input | 1 | Wipe a stored digest |
| zero_role | input | 1 | Role whose digest is wiped |
| svc_req | input | 8 | One request bit per service |
| svc_grant | output | 8 | Granted services |
| session_valid | output | 1 | A session is open |
| active_role | output | 1 | Role of the open session |
| auth_done | output | 1 | Attempt finished (pulse) |
| auth_pass | output | 1 | Outcome of the last attempt |
| hash_req | output | 1 | Digest request to the hash engine |
| hash_data | output | 256 | Credential to digest |
| hash_ack | input | 1 | Hash engine answer strobe |
| hash_digest | input | 256 | Digest from the hash engine |
| stored_dig_off | input | 256 | Stored officer digest |
| stored_dig_usr | input | 256 | Stored user digest |
| factory_state | input | 2 | Factory credential still present (bit 1 officer, bit 0 user) |
| nv_we | output | 1 | Write strobe to the store |
| nv_sel | output | 1 | Role of the written digest |
| nv_data | output | 256 | Digest to write |
| nv_clr_factory | output | 1 | Write replaces a factory credential |

## Verification
A corrupted session register would show at once on `session_valid` and `svc_grant`. A wrongly latched role shows in the same cycle as a grant vector that matches the other role's mask. A lost or miscounted attempt timer shows as an `auth_done` pulse that is early, late or missing, which the bench catches by counting edges from acceptance. A stale captured credential shows on `hash_data`, or as a wrong `nv_data` one cycle after the hash answer. A broken permission rule shows as a write strobe, or as a missing one, within a few cycles of the request.

// File: rtl/role_auth_ctrl.sv
module role_auth_ctrl #(
  parameter int CRED_W = 256,
  parameter int N_SVC = 8,
  parameter int MGMT_IDX = 0,
  parameter int ATTEMPT_CYCLES = 75_000_000,
  parameter logic [N_SVC-1:0] OFF_MASK = 8'b1100_0011,
  parameter logic [N_SVC-1:0] USR_MASK = 8'b0011_1101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              login_req,
  input  logic              login_role,
  input  logic [CRED_W-1:0] login_cred,
  input  logic              logout_req,
  input  logic              selftest_start,
  input  logic              upd_req,
  input  logic              upd_role,
  input  logic [CRED_W-1:0] upd_cred,
  input  logic              zero_req,
  input  logic              zero_role,
  input  logic [N_SVC-1:0]  svc_req,
  output logic [N_SVC-1:0]  svc_grant,
  output logic              session_valid,
  output logic              active_role,
  output logic              auth_done,
  output logic              auth_pass,
  output logic              hash_req,
  output logic [CRED_W-1:0] hash_data,
  input  logic              hash_ack,
  input  logic [CRED_W-1:0] hash_digest,
  input  logic [CRED_W-1:0] stored_dig_off,
  input  logic [CRED_W-1:0] stored_dig_usr,
  input  logic [1:0]        factory_state,
  output logic              nv_we,
  output logic              nv_sel,
  output logic [CRED_W-1:0] nv_data,
  output logic              nv_clr_factory
);

  localparam int CW = $clog2(ATTEMPT_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(ATTEMPT_CYCLES - 1);
  localparam logic [N_SVC-1:0] MGMT_BIT = N_SVC'(1) << MGMT_IDX;

  typedef enum logic [1:0] {S_IDLE, S_HASH, S_HOLD} st_t;

  st_t               st;
  logic [CW-1:0]     cnt;
  logic              is_upd, tgt_role, pass_q;
  logic [CRED_W-1:0] cred_q;

  logic [N_SVC-1:0] role_mask, allow, eff;
  logic idle, calm, mgmt_ok, upd_ok, zero_ok;
  logic take_login, take_upd, take_zero;

  assign role_mask = active_role ? OFF_MASK : USR_MASK;
  assign allow     = (|factory_state) ? MGMT_BIT : {N_SVC{1'b1}};
  assign eff       = session_valid ? (role_mask & allow) : '0;
  assign svc_grant = svc_req & eff;
  assign mgmt_ok   = |(eff & MGMT_BIT);
  assign upd_ok    = mgmt_ok && (active_role || !upd_role);
  assign zero_ok   = mgmt_ok && (active_role || !zero_role);

  assign idle       = (st == S_IDLE);
  assign calm       = idle && !selftest_start && !logout_req;
  assign take_login = calm && login_req;
  assign take_upd   = calm && !login_req && upd_req && upd_ok;
  assign take_zero  = calm && !login_req && !upd_req && zero_req && zero_ok;

  assign hash_req  = (st == S_HASH);
  assign hash_data = cred_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st             <= S_IDLE;
      cnt            <= '0;
      is_upd         <= 1'b0;
      tgt_role       <= 1'b0;
      pass_q         <= 1'b0;
      cred_q         <= '0;
      session_valid  <= 1'b0;
      active_role    <= 1'b0;
      auth_done      <= 1'b0;
      auth_pass      <= 1'b0;
      nv_we          <= 1'b0;
      nv_sel         <= 1'b0;
      nv_data        <= '0;
      nv_clr_factory <= 1'b0;
    end else begin
      auth_done <= 1'b0;
      nv_we     <= 1'b0;
      if (selftest_start) begin
        session_valid <= 1'b0;
        active_role   <= 1'b0;
        st            <= S_IDLE;
        cred_q        <= '0;
      end else begin
        if (logout_req) begin
          session_valid <= 1'b0;
          active_role   <= 1'b0;
        end
        if (st != S_IDLE && cnt != LAST) cnt <= cnt + 1'b1;
        unique case (st)
          S_IDLE: begin
            if (take_login) begin
              cnt      <= '0;
              tgt_role <= login_role;
              is_upd   <= 1'b0;
              pass_q   <= 1'b0;
              if (session_valid) begin
                st <= S_HOLD;
              end else begin
                cred_q <= login_cred;
                st     <= S_HASH;
              end
            end else if (take_upd) begin
              tgt_role <= upd_role;
              cred_q   <= upd_cred;
              is_upd   <= 1'b1;
              st       <= S_HASH;
            end else if (take_zero) begin
              nv_we          <= 1'b1;
              nv_sel         <= zero_role;
              nv_data        <= '1;
              nv_clr_factory <= 1'b0;
            end
          end
          S_HASH: begin
            if (hash_ack) begin
              cred_q <= '0;
              if (is_upd) begin
                nv_we          <= 1'b1;
                nv_sel         <= tgt_role;
                nv_data        <= hash_digest;
                nv_clr_factory <= 1'b1;
                st             <= S_IDLE;
              end else begin
                pass_q <= (hash_digest == (tgt_role ? stored_dig_off : stored_dig_usr));
                st     <= S_HOLD;
              end
            end
          end
          S_HOLD: begin
            if (cnt == LAST) begin
              st        <= S_IDLE;
              auth_done <= 1'b1;
              auth_pass <= pass_q;
              if (pass_q && !logout_req) begin
                session_valid <= 1'b1;
                active_role   <= tgt_role;
              end
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  AST_OPEN_BY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(session_valid) |-> (auth_done && auth_pass)); // R2
  AST_ROLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (session_valid && $past(session_valid)) |-> $stable(active_role)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    auth_done |=> !auth_done); // R4
  AST_HASH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (hash_req && !hash_ack && !selftest_start) |=> (hash_req && $stable(hash_data))); // R5
  AST_NO_GRANT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !session_valid |-> (svc_grant == '0)); // R6
  AST_FACTORY_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (|factory_state) |-> ((svc_grant & ~MGMT_BIT) == '0)); // R7
  AST_WIPE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_we && !nv_clr_factory) |-> (nv_data == '1)); // R9
  AST_SELFTEST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    selftest_start |=> (!session_valid && !auth_done && !hash_req)); // R10

endmodule

// File: tb/tb_role_auth_ctrl.sv
`timescale 1ns/1ps
module tb_role_auth_ctrl;
  localparam int A = 20;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, login_req, login_role, logout_req, selftest_start;
  logic upd_req, upd_role, zero_req, zero_role, hash_ack;
  logic [255:0] login_cred, upd_cred, hash_digest, dig_off, dig_usr;
  logic [7:0] svc_req, svc_grant;
  logic [1:0] fac;
  logic session_valid, active_role, auth_done, auth_pass, hash_req;
  logic nv_we, nv_sel, nv_clr_factory;
  logic [255:0] hash_data, nv_data;
  int lat;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  role_auth_ctrl #(.ATTEMPT_CYCLES(A)) dut (
    .clk(clk), .rst_n(rst_n), .login_req(login_req), .login_role(login_role),
    .login_cred(login_cred), .logout_req(logout_req), .selftest_start(selftest_start),
    .upd_req(upd_req), .upd_role(upd_role), .upd_cred(upd_cred), .zero_req(zero_req),
    .zero_role(zero_role), .svc_req(svc_req), .svc_grant(svc_grant),
    .session_valid(session_valid), .active_role(active_role), .auth_done(auth_done),
    .auth_pass(auth_pass), .hash_req(hash_req), .hash_data(hash_data), .hash_ack(hash_ack),
    .hash_digest(hash_digest), .stored_dig_off(dig_off), .stored_dig_usr(dig_usr),
    .factory_state(fac), .nv_we(nv_we), .nv_sel(nv_sel), .nv_data(nv_data),
    .nv_clr_factory(nv_clr_factory));

  function automatic logic [255:0] cred(input int i);
    return {8{32'h1000_0000 + 32'(i) * 32'h0101_0101}};
  endfunction

  function automatic logic [255:0] model_digest(input logic [255:0] x);
    return {x[127:0], x[255:128]} ^ {8{32'h5A3C_96E1}};
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      hash_ack <= 1'b0; lat <= 0; hash_digest <= '0;
    end else if (hash_ack) begin
      hash_ack <= 1'b0;
    end else if (hash_req) begin
      if (lat == 2) begin
        hash_ack <= 1'b1; hash_digest <= model_digest(hash_data); lat <= 0;
      end else lat <= lat + 1;
    end else lat <= 0;
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      dig_off <= model_digest(cred(0)); dig_usr <= model_digest(cred(1)); fac <= 2'b11;
    end else if (nv_we) begin
      if (nv_sel) dig_off <= nv_data; else dig_usr <= nv_data;
      if (nv_clr_factory) fac[nv_sel] <= 1'b0;
    end
  end

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_login(input logic role, input logic [255:0] c, output int cyc);
    @(negedge clk); login_req = 1; login_role = role; login_cred = c;
    @(posedge clk); @(negedge clk); login_req = 0;
    cyc = 0;
    while (!auth_done && cyc < 200) begin @(negedge clk); cyc++; end
  endtask

  task automatic do_logout();
    @(negedge clk); logout_req = 1;
    @(posedge clk); @(negedge clk); logout_req = 0;
    chk("R10 logout clears session", session_valid, 0);
  endtask

  task automatic grant_of(input logic [7:0] req, output logic [7:0] g);
    svc_req = req; #1; g = svc_grant; svc_req = 0;
  endtask

  task automatic do_upd(input logic role, input logic [255:0] c);
    int n = 0;
    bit got = 0;
    @(negedge clk); upd_req = 1; upd_role = role; upd_cred = c;
    @(posedge clk); @(negedge clk); upd_req = 0;
    while (!nv_we && n < 50) begin
      if (hash_req && !got) begin got = 1; chk("R5 hash_data", hash_data, c); end
      @(negedge clk); n++;
    end
    chk("R8 nv_we", nv_we, 1);
    chk("R8 nv_sel", nv_sel, role);
    chk("R8 nv_data", nv_data, model_digest(c));
    chk("R8 nv_clr_factory", nv_clr_factory, 1);
    @(negedge clk);
  endtask

  task automatic quiet(input string r);
    bit seen = 0;
    repeat (6) begin @(negedge clk); if (nv_we || hash_req) seen = 1; end
    chk(r, seen, 0);
  endtask

  localparam logic [3:0] LOGIN_TAB [0:5] = '{4'b1_00_1, 4'b0_01_1, 4'b1_01_0,
                                             4'b0_00_0, 4'b1_10_0, 4'b0_11_0};

  initial begin
    #400000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int cyc;
    logic [7:0] g;
    rst_n = 0; login_req = 0; login_role = 0; login_cred = 0; logout_req = 0;
    selftest_start = 0; upd_req = 0; upd_role = 0; upd_cred = 0; zero_req = 0;
    zero_role = 0; svc_req = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R11 session", session_valid, 0);
    chk("R11 role", active_role, 0);
    chk("R11 done", auth_done, 0);
    chk("R11 hash_req", hash_req, 0);
    chk("R11 nv_we", nv_we, 0);
    chk("R11 grant", svc_grant, 0);
    svc_req = 0; rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < 6; i++) begin
      logic [3:0] v = LOGIN_TAB[i];
      do_login(v[3], cred(int'(v[2:1])), cyc);
      chk("R4 attempt length", cyc, A);
      chk("R2 auth_pass", auth_pass, v[0]);
      chk("R1 session_valid", session_valid, v[0]);
      if (v[0]) begin
        chk("R1 active_role", active_role, v[3]);
        grant_of(8'hFF, g);
        chk("R7 factory lock", g, 8'h01);
        do_logout();
      end
    end

    do_login(1, cred(0), cyc);
    do_login(0, cred(1), cyc);
    chk("R4 refusal length", cyc, A);
    chk("R3 refused pass", auth_pass, 0);
    chk("R3 session kept", session_valid, 1);
    chk("R3 role kept", active_role, 1);

    do_upd(1, cred(2));
    grant_of(8'hFF, g);
    chk("R7 still locked", g, 8'h01);
    do_upd(0, cred(3));
    grant_of(8'hFF, g);
    chk("R6 officer mask", g, 8'hC3);
    grant_of(8'h5A, g);
    chk("R6 officer partial", g, 8'h42);
    do_logout();

    do_login(0, cred(3), cyc);
    chk("R2 user new cred", session_valid, 1);
    grant_of(8'hFF, g);
    chk("R6 user mask", g, 8'h3D);
    @(negedge clk); upd_req = 1; upd_role = 1; upd_cred = cred(5);
    @(posedge clk); @(negedge clk); upd_req = 0;
    quiet("R8 user update of officer refused");
    @(negedge clk); zero_req = 1; zero_role = 1;
    @(posedge clk); @(negedge clk); zero_req = 0;
    quiet("R9 user wipe of officer refused");
    do_logout();

    do_login(1, cred(0), cyc);
    chk("R2 old factory cred fails", auth_pass, 0);
    chk("R2 no session", session_valid, 0);
    do_login(1, cred(2), cyc);
    chk("R2 officer new cred", session_valid, 1);

    @(negedge clk); zero_req = 1; zero_role = 0;
    @(posedge clk); @(negedge clk); zero_req = 0;
    chk("R9 nv_we", nv_we, 1);
    chk("R9 nv_sel", nv_sel, 0);
    chk("R9 nv_data", nv_data, {256{1'b1}});
    chk("R9 nv_clr_factory", nv_clr_factory, 0);

    @(negedge clk); selftest_start = 1;
    @(posedge clk); @(negedge clk); selftest_start = 0;
    chk("R10 selftest clears", session_valid, 0);

    do_login(0, cred(3), cyc);
    chk("R9 wiped user digest refuses", auth_pass, 0);

    begin
      bit seen = 0;
      @(negedge clk); login_req = 1; login_role = 1; login_cred = cred(2);
      @(posedge clk); @(negedge clk); login_req = 0;
      repeat (4) @(negedge clk);
      selftest_start = 1;
      @(posedge clk); @(negedge clk); selftest_start = 0;
      repeat (A + 5) begin @(negedge clk); if (auth_done || hash_req) seen = 1; end
      chk("R10 abort no done", seen, 0);
      chk("R10 abort no session", session_valid, 0);
    end

    grant_of(8'hFF, g);
    chk("R6 no session no grant", g, 8'h00);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule